// File: doc/BRIEF.md
# Policer Rate and Burst Encoder

This block converts a requested information rate (bits per second, up to 100 Gbps) and a bucket depth (bytes) into the compact floating-point fields a token-bucket policer consumes. Each value is encoded as (1 + m/256) · 2^e. The rate also gets a refill-divider exponent that stretches the token refill period for slow rates. Only integer arithmetic is used, with a fixed scale of one million standing in for fractional precision.

A request enters on a valid/ready handshake. `in_ready` is high only while the block is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While a conversion is running or a result is waiting, `in_ready` stays low and nothing on the request pins is looked at. The burst fields are worked out at once from the captured burst. The rate is normalised one doubling or halving per clock, and its mantissa then comes from an eight-step restoring divider. The result is offered with `out_valid` and held, unchanged, until the consumer raises `out_ready`. This back-pressure can last any number of cycles.

Top module: `pol_encoder`

## Requirements
- R1: `in_ready` is high only when no request is in flight and no result is pending. A request is taken only on an edge with `in_valid` and `in_ready` both high. Request pins that change while `in_ready` is low do not alter the result being produced.
- R2: Once `out_valid` is high, it and all five result fields stay constant until an edge with `out_ready` high. On the cycle after that edge, `out_valid` is low and `in_ready` is high.
- R3: `burst_exp` equals floor(log2(burst_bytes)). A burst of 0 gives `burst_exp` = 0 and `burst_mant` = 0.
- R4: For a burst below 256, `burst_mant` is 0.
- R5: For a burst of 256 or more, `burst_exp` is the logarithm limited to 22. `burst_mant` is the low 8 bits of (burst − 2^floor(log2 burst)) / 2^(burst_exp − 8), using an integer quotient.
- R6: The working value is V = rate_bps × 64. If V < 256,000,000, V is doubled once per clock and `rate_div` is incremented each time. Doubling stops when V ≥ 256,000,000 or `rate_div` reaches 15. In this case `rate_exp` is 0.
- R7: If V ≥ 256,000,000 at the start, V is halved once per clock while V ≥ 512,000,000 and fewer than 23 halvings have been done. Each halving counts toward the exponent. `rate_exp` is that count limited to 22, and `rate_div` is 0.
- R8: `rate_mant` = floor((V − 256,000,000) / 1,000,000) for the final V. It is 0 if the final V is below 256,000,000 and 255 if it is 512,000,000 or more.
- R9: `out_valid` is first high after the (S + 9)th rising edge following the accepting edge. S is the number of doublings or halvings performed.
- R10: After reset, `in_ready` is 1, `out_valid` is 0 and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| rate_bps | input | RATE_W (37) | Requested rate in bits per second |
| burst_bytes | input | BURST_W (32) | Requested bucket depth in bytes |
| out_valid | output | 1 | Result fields valid |
| out_ready | input | 1 | Consumer takes the result |
| rate_exp | output | 5 | Rate exponent |
| rate_mant | output | 8 | Rate mantissa |
| rate_div | output | 4 | Refill-divider exponent |
| burst_exp | output | 5 | Burst exponent |
| burst_mant | output | 8 | Burst mantissa |

## Verification
All five fields become valid together, S + 9 edges after the accepting edge. S is the number of normalisation steps the bench's own model predicts, and it runs from 0 (rate already in range) to 15 (divider limit). The bench counts rising edges from acceptance and samples `out_valid` and the fields on falling edges only, so the measured latency must equal S + 9 exactly. Stability under back-pressure and the return of `in_ready` are also sampled on falling edges, one edge after the handshake that releases them.

// File: rtl/pol_enc_pkg.sv
package pol_enc_pkg;
  localparam int unsigned EXP_W  = 5;
  localparam int unsigned MANT_W = 8;
  localparam int unsigned DIV_W  = 4;

  localparam longint unsigned UNIT = 64'd1000000;
  localparam longint unsigned LOW  = 64'd256000000;
  localparam longint unsigned HIGH = 64'd512000000;
  localparam int unsigned EXP_MAX  = 22;
  localparam int unsigned DIV_MAX  = 15;
  localparam int unsigned SCALE_SH = 6;   // x64
  localparam int unsigned REM_W    = 28;  // holds HIGH-LOW-1
  localparam int unsigned QBITS    = MANT_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_DIV  = 2'd2,
    ST_DONE = 2'd3
  } enc_state_t;
endpackage

// File: rtl/pol_burst_enc.sv
module pol_burst_enc
  import pol_enc_pkg::*;
#(
  parameter int unsigned BURST_W = 32
) (
  input  logic [BURST_W-1:0] burst,
  output logic [EXP_W-1:0]   exp_o,
  output logic [MANT_W-1:0]  mant_o
);
  localparam int unsigned LG_W = $clog2(BURST_W);

  logic [LG_W-1:0]    lg;
  logic [LG_W-1:0]    exp_cl;
  logic [LG_W-1:0]    shamt;
  logic [BURST_W-1:0] rem;
  logic               big;

  always_comb begin
    lg = '0;
    for (int i = 0; i < BURST_W; i++) begin
      if (burst[i]) lg = LG_W'(i);
    end
    rem    = (burst == '0) ? '0 : (burst ^ (BURST_W'(1) << lg));
    big    = |burst[BURST_W-1:8];
    exp_cl = (lg > LG_W'(EXP_MAX)) ? LG_W'(EXP_MAX) : lg;
    shamt  = exp_cl - LG_W'(8);
    exp_o  = big ? EXP_W'(exp_cl) : EXP_W'(lg);
    mant_o = big ? MANT_W'(rem >> shamt) : '0;
  end
endmodule

// File: rtl/pol_rate_norm.sv
module pol_rate_norm
  import pol_enc_pkg::*;
#(
  parameter int unsigned RATE_W = 37,
  localparam int unsigned VAL_W = RATE_W + SCALE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RATE_W-1:0] rate,
  output logic              settled,
  output logic [VAL_W-1:0]  val,
  output logic [DIV_W-1:0]  div_cnt,
  output logic [EXP_W-1:0]  exp_cnt
);
  logic             grow;
  logic             dbl_step;
  logic             hlv_step;
  logic [VAL_W-1:0] scaled;

  assign scaled   = {rate, SCALE_SH'(0)};
  assign dbl_step = grow && (val < VAL_W'(LOW)) && (div_cnt != DIV_W'(DIV_MAX));
  assign hlv_step = !grow && (val >= VAL_W'(HIGH)) && (exp_cnt <= EXP_W'(EXP_MAX));
  assign settled  = !dbl_step && !hlv_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val     <= '0;
      grow    <= 1'b0;
      div_cnt <= '0;
      exp_cnt <= '0;
    end else if (load) begin
      val     <= scaled;
      grow    <= (scaled < VAL_W'(LOW));
      div_cnt <= '0;
      exp_cnt <= '0;
    end else if (dbl_step) begin
      val     <= val << 1;
      div_cnt <= div_cnt + 1'b1;
    end else if (hlv_step) begin
      val     <= val >> 1;
      exp_cnt <= exp_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pol_mant_div.sv
module pol_mant_div
  import pol_enc_pkg::*;
#(
  parameter int unsigned VAL_W = 43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VAL_W-1:0]  val,
  output logic              last,
  output logic [MANT_W-1:0] quot
);
  localparam int unsigned K_W = $clog2(QBITS);

  logic             busy;
  logic [K_W-1:0]   k;
  logic [REM_W-1:0] rem;
  logic [REM_W-1:0] trial;
  logic [REM_W-1:0] num;

  always_comb begin
    if (val >= VAL_W'(HIGH))     num = REM_W'(UNIT * 255);
    else if (val < VAL_W'(LOW))  num = '0;
    else                         num = REM_W'(val - VAL_W'(LOW));
  end

  assign trial = REM_W'(UNIT) << k;
  assign last  = busy && (k == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      k    <= '0;
      rem  <= '0;
      quot <= '0;
    end else if (start) begin
      busy <= 1'b1;
      k    <= K_W'(QBITS - 1);
      rem  <= num;
      quot <= '0;
    end else if (busy) begin
      if (rem >= trial) begin
        rem     <= rem - trial;
        quot[k] <= 1'b1;
      end
      if (k == '0) busy <= 1'b0;
      else         k    <= k - 1'b1;
    end
  end
endmodule

// File: rtl/pol_encoder.sv
module pol_encoder
  import pol_enc_pkg::*;
#(
  parameter int unsigned RATE_W  = 37,
  parameter int unsigned BURST_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [RATE_W-1:0]  rate_bps,
  input  logic [BURST_W-1:0] burst_bytes,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [EXP_W-1:0]   rate_exp,
  output logic [MANT_W-1:0]  rate_mant,
  output logic [DIV_W-1:0]   rate_div,
  output logic [EXP_W-1:0]   burst_exp,
  output logic [MANT_W-1:0]  burst_mant
);
  localparam int unsigned VAL_W = RATE_W + SCALE_SH;

  enc_state_t        state;
  logic              accept;
  logic              settled;
  logic              div_start;
  logic              div_last;
  logic [VAL_W-1:0]  nval;
  logic [EXP_W-1:0]  exp_cnt;
  logic [EXP_W-1:0]  b_exp_c;
  logic [MANT_W-1:0] b_mant_c;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign accept    = in_valid && in_ready;
  assign div_start = (state == ST_NORM) && settled;

  pol_burst_enc #(.BURST_W(BURST_W)) u_burst (
    .burst (burst_bytes),
    .exp_o (b_exp_c),
    .mant_o(b_mant_c)
  );

  pol_rate_norm #(.RATE_W(RATE_W)) u_norm (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .rate   (rate_bps),
    .settled(settled),
    .val    (nval),
    .div_cnt(rate_div),
    .exp_cnt(exp_cnt)
  );

  pol_mant_div #(.VAL_W(VAL_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .val  (nval),
    .last (div_last),
    .quot (rate_mant)
  );

  assign rate_exp = (exp_cnt > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      burst_exp  <= '0;
      burst_mant <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state      <= ST_NORM;
          burst_exp  <= b_exp_c;
          burst_mant <= b_mant_c;
        end
        ST_NORM: if (settled)   state <= ST_DIV;
        ST_DIV:  if (div_last)  state <= ST_DONE;
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pol_encoder_chk.sv
module pol_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [4:0] rate_exp,
  input logic [7:0] rate_mant,
  input logic [3:0] rate_div,
  input logic [4:0] burst_exp,
  input logic [7:0] burst_mant
);
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(rate_exp) &&
      $stable(rate_mant) && $stable(rate_div) && $stable(burst_exp) &&
      $stable(burst_mant)));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  p_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && burst_exp < 5'd8) |-> (burst_mant == 8'd0));

  p_bexp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (burst_exp <= 5'd22));

  p_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rate_div != 4'd0) |-> (rate_exp == 5'd0));

  p_rexp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rate_exp <= 5'd22));
endmodule

bind pol_encoder pol_encoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .rate_exp  (rate_exp),
  .rate_mant (rate_mant),
  .rate_div  (rate_div),
  .burst_exp (burst_exp),
  .burst_mant(burst_mant)
);

// File: tb/tb_pol_encoder.sv
module tb_pol_encoder;
  localparam longint unsigned LOW  = 64'd256000000;
  localparam longint unsigned HIGH = 64'd512000000;
  localparam longint unsigned UNIT = 64'd1000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [36:0] rate_bps = '0;
  logic [31:0] burst_bytes = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [4:0]  rate_exp;
  logic [7:0]  rate_mant;
  logic [3:0]  rate_div;
  logic [4:0]  burst_exp;
  logic [7:0]  burst_mant;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  pol_encoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rate_bps(rate_bps), .burst_bytes(burst_bytes), .out_valid(out_valid),
    .out_ready(out_ready), .rate_exp(rate_exp), .rate_mant(rate_mant),
    .rate_div(rate_div), .burst_exp(burst_exp), .burst_mant(burst_mant)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model of the requirements
  task automatic model(input longint unsigned r, input longint unsigned b,
                       output int re, output int rm, output int rd,
                       output int be, output int bm, output int steps);
    longint unsigned v = r * 64;
    int e = 0;
    int d = 0;
    int lg = 0;
    int ec;
    steps = 0;
    if (v < LOW) begin
      while (v < LOW && d < 15) begin v = v * 2; d++; steps++; end
    end else begin
      while (v >= HIGH && e <= 22) begin v = v / 2; e++; steps++; end
    end
    re = (e > 22) ? 22 : e;
    rd = d;
    if (v >= HIGH)     rm = 255;
    else if (v < LOW)  rm = 0;
    else               rm = int'((v - LOW) / UNIT);
    for (int i = 0; i < 32; i++) if (b[i]) lg = i;
    if (b < 256) begin
      be = lg; bm = 0;
    end else begin
      ec = (lg > 22) ? 22 : lg;
      be = ec;
      bm = int'(((b - (64'd1 << lg)) >> (ec - 8)) & 64'hFF);
    end
  endtask

  task automatic check_fields(input string req, input longint unsigned r,
                              input longint unsigned b, input int lat);
    int re, rm, rd, be, bm, s;
    model(r, b, re, rm, rd, be, bm, s);
    chk("R9", "latency", lat, s + 9);
    chk(req, "rate_exp", rate_exp, re);
    chk(req, "rate_mant", rate_mant, rm);
    chk(req, "rate_div", rate_div, rd);
    chk(req, "burst_exp", burst_exp, be);
    chk(req, "burst_mant", burst_mant, bm);
  endtask

  // accept a request, then wait for the result; returns edge count
  task automatic issue(input longint unsigned r, input longint unsigned b,
                       input bit junk, output int lat);
    @(negedge clk);
    in_valid = 1'b1; rate_bps = 37'(r); burst_bytes = 32'(b);
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    if (junk) begin
      rate_bps = 37'd12345; burst_bytes = 32'd7777;  // held valid, busy
    end else in_valid = 1'b0;
    while (!out_valid && lat < 100) begin
      if (junk) chk("R1", "in_ready while busy", in_ready, 0);
      @(posedge clk); lat++; @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic pop();
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R2", "in_ready after pop", in_ready, 1);
    chk("R2", "out_valid after pop", out_valid, 0);
  endtask

  task automatic t_case(input string req, input longint unsigned r,
                        input longint unsigned b);
    int lat;
    issue(r, b, 1'b0, lat);
    check_fields(req, r, b, lat);
    pop();
  endtask

  task automatic t_busy_ignore();
    int lat;
    issue(64'd1000000000, 64'd1500, 1'b1, lat);
    check_fields("R1", 64'd1000000000, 64'd1500, lat);
    pop();
  endtask

  task automatic t_backpressure();
    int lat;
    logic [32:0] snap;
    issue(64'd100000000000, 64'd65535, 1'b0, lat);
    snap = {rate_exp, rate_mant, rate_div, burst_exp, burst_mant};
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R2", "out_valid held", out_valid, 1);
      chk("R2", "fields held", {rate_exp, rate_mant, rate_div, burst_exp, burst_mant}, snap);
    end
    check_fields("R2", 64'd100000000000, 64'd65535, lat);
    pop();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "in_ready", in_ready, 1);
    chk("R10", "out_valid", out_valid, 0);
    chk("R10", "fields", {rate_exp, rate_mant, rate_div, burst_exp, burst_mant}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_case("R7", 64'd1000000000, 64'd1500);       // exp 7, mant 244
    t_case("R6", 64'd1000000, 64'd100);           // div 2, small burst
    t_case("R6", 64'd1, 64'd255);                 // divider cap 15
    t_case("R3", 64'd0, 64'd0);                   // zero inputs
    t_case("R8", 64'd4000000, 64'd256);           // exactly lower bound
    t_case("R8", 64'd8000000, 64'd257);           // exactly upper bound
    t_case("R5", 64'd3000000, 64'h0080C000);      // clamp 22, mant 3
    t_case("R5", 64'd777777777, 64'hFFFFFFFF);    // low 8 bits kept
    t_case("R4", 64'd99999999999, 64'd1);
    t_case("R7", 64'd137438953471, 64'd4096);     // full-scale rate
    t_busy_ignore();
    t_backpressure();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule